// File: doc/BRIEF.md
# Machine-Cycle Qualified Reset Controller

This block turns the raw, active-high reset pin of an 8-bit microcontroller into a clean internal reset for the core. The pin first passes through a two-flop synchroniser. The block then counts machine-cycle strobes while the synchronised pin stays high. The internal reset is raised only when the pin has been high across the required number of strobes. It is lowered on a clock edge that carries a strobe, one machine cycle after the synchronised pin has gone low. While the internal reset is high, the block requests weak pull-ups on all port pins. The block produces no RAM clear, so a reset taken while the part is running leaves on-chip RAM untouched.

A separate power-up pulse forces the internal reset straight away. It also sets a sticky power-on flag. That flag lives in the power-control register and is visible on a read output. Pin resets never clear the flag. Only a software write with the flag bit at 0 clears it, so firmware can tell a cold start from a warm one.

Top module: `rstctl_top`

## Requirements
- R1: The internal reset `core_rst` rises only after the synchronised pin has been high on `QUAL_TICKS` (default 2) clock edges that carry `mc_tick`. It rises on the edge of the last such strobe. With the pin raised just after a strobe edge and a strobe every 12 clocks, `core_rst` is still 0 after 23 clocks and is 1 after 24 clocks.
- R2: If the synchronised pin goes low before the qualifying count is reached, the count restarts from zero. Two separate high pulses that each span a single strobe never raise `core_rst`.
- R3: Once raised, `core_rst` stays high while the pin is high. After the synchronised pin goes low, `core_rst` falls on the next clock edge that carries `mc_tick`. With the pin dropped just after a strobe edge and a 12-clock strobe period, `core_rst` is 1 after 11 clocks and 0 after 12 clocks.
- R4: If the pin returns high while the release is pending, `core_rst` stays high without a gap.
- R5: A one-clock `pwr_up` pulse raises `core_rst` and sets `pof_rd` on the next clock edge, with no qualification.
- R6: A write (`reg_wr_en` = 1) with `reg_wr_bit` = 0 clears the power-on flag on the next edge. A write with `reg_wr_bit` = 1 leaves it unchanged.
- R7: Pin resets, including their assertion and their release, do not change the power-on flag.
- R8: When `pwr_up` and a clearing write occur in the same cycle, the flag ends up set.
- R9: `port_pullup` is 1 exactly while `core_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| mc_tick | input | 1 | One-clock strobe, once per machine cycle |
| rst_pin | input | 1 | Raw external reset pin, active high, asynchronous |
| pwr_up | input | 1 | Power-up indication pulse |
| reg_wr_en | input | 1 | Write strobe for the power-control register |
| reg_wr_bit | input | 1 | Value written to the power-on flag bit |
| core_rst | output | 1 | Qualified internal reset, active high |
| pof_rd | output | 1 | Read value of the power-on flag |
| port_pullup | output | 1 | Weak pull-up request for the port pins |

## Verification
The pin is driven with a long press aligned to a strobe edge, which pins down the exact assertion edge, and with a matching aligned drop, which pins down the exact release edge. Two short presses that each span one strobe separate a count that restarts from one that accumulates. A drop followed by a quick return separates a pending release from a completed one. Flag writes of 0 and 1 are applied on their own and together with a power-up pulse, and pin resets run with the flag set and with it clear. Together these show that only a clearing write or power-up moves the flag, and which of the two wins when they coincide.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  typedef enum logic [1:0] {
    RS_WATCH = 2'd0,
    RS_HOLD  = 2'd1,
    RS_DRAIN = 2'd2
  } rs_state_e;

  // True when one more strobe brings the tally to the limit.
  function automatic bit tally_done(int unsigned tally, int unsigned limit);
    return (tally + 1) >= limit;
  endfunction

  function automatic int unsigned tally_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shreg = '0;

  always_ff @(posedge clk) begin
    shreg <= {shreg[STAGES-2:0], din};
  end

  assign dout = shreg[STAGES-1];
endmodule

// File: rtl/rstctl_qual.sv
module rstctl_qual
  import rstctl_pkg::*;
#(
  parameter int QUAL_TICKS = 2,
  parameter int REL_TICKS  = 1
) (
  input  logic clk,
  input  logic mc_tick,
  input  logic sync_pin,
  input  logic pwr_up,
  output logic core_rst,
  output logic qual_hit,
  output logic rel_hit
);
  localparam int CNT_W = tally_width(QUAL_TICKS, REL_TICKS);

  rs_state_e        state = RS_WATCH;
  rs_state_e        state_nx;
  logic [CNT_W-1:0] cnt = '0;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    qual_hit = 1'b0;
    rel_hit  = 1'b0;
    unique case (state)
      RS_WATCH: begin
        if (!sync_pin) begin
          cnt_nx = '0;
        end else if (mc_tick) begin
          if (tally_done(32'(cnt), QUAL_TICKS)) begin
            qual_hit = 1'b1;
            state_nx = RS_HOLD;
            cnt_nx   = '0;
          end else begin
            cnt_nx = cnt + CNT_W'(1);
          end
        end
      end
      RS_HOLD: begin
        if (!sync_pin) begin
          state_nx = RS_DRAIN;
          cnt_nx   = '0;
        end
      end
      RS_DRAIN: begin
        if (sync_pin) begin
          state_nx = RS_HOLD;
          cnt_nx   = '0;
        end else if (mc_tick) begin
          if (tally_done(32'(cnt), REL_TICKS)) begin
            rel_hit  = 1'b1;
            state_nx = RS_WATCH;
            cnt_nx   = '0;
          end else begin
            cnt_nx = cnt + CNT_W'(1);
          end
        end
      end
      default: begin
        state_nx = RS_WATCH;
        cnt_nx   = '0;
      end
    endcase
    if (pwr_up) begin
      state_nx = RS_HOLD;
      cnt_nx   = '0;
    end
  end

  always_ff @(posedge clk) begin
    state <= state_nx;
    cnt   <= cnt_nx;
  end

  assign core_rst = (state != RS_WATCH);

  // R1
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (pwr_up)
    $rose(core_rst) |-> ($past(pwr_up) || ($past(mc_tick) && $past(sync_pin))));

  // R3
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (pwr_up)
    $fell(core_rst) |-> ($past(mc_tick) && !$past(sync_pin) && !$past(pwr_up)));

  // R2
  watch_cnt_range_chk: assert property (@(posedge clk) disable iff (pwr_up)
    (state == RS_WATCH) |-> (cnt < CNT_W'(QUAL_TICKS)));

  // R4
  drain_rehigh_chk: assert property (@(posedge clk) disable iff (pwr_up)
    (state == RS_DRAIN && sync_pin) |=> core_rst);
endmodule

// File: rtl/rstctl_pof.sv
module rstctl_pof (
  input  logic clk,
  input  logic pwr_up,
  input  logic wr_en,
  input  logic wr_bit,
  output logic flag,
  output logic clr_evt
);
  logic flag_q = 1'b0;

  assign clr_evt = wr_en && !wr_bit && !pwr_up;

  always_ff @(posedge clk) begin
    if (pwr_up)       flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
  end

  assign flag = flag_q;

  // R5
  flag_after_pwr_chk: assert property (@(posedge clk) disable iff (pwr_up)
    $fell(pwr_up) |-> flag);

  // R6
  flag_clear_cause_chk: assert property (@(posedge clk) disable iff (pwr_up)
    $fell(flag) |-> ($past(wr_en) && !$past(wr_bit)));

  // R7
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (pwr_up)
    $rose(flag) |-> $past(pwr_up));
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_TICKS  = 2,
  parameter int REL_TICKS   = 1
) (
  input  logic clk,
  input  logic mc_tick,
  input  logic rst_pin,
  input  logic pwr_up,
  input  logic reg_wr_en,
  input  logic reg_wr_bit,
  output logic core_rst,
  output logic pof_rd,
  output logic port_pullup
);
  logic sync_pin;
  logic qual_hit;
  logic rel_hit;
  logic pof_clr_evt;

  rstctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .din  (rst_pin),
    .dout (sync_pin)
  );

  rstctl_qual #(.QUAL_TICKS(QUAL_TICKS), .REL_TICKS(REL_TICKS)) u_qual (
    .clk      (clk),
    .mc_tick  (mc_tick),
    .sync_pin (sync_pin),
    .pwr_up   (pwr_up),
    .core_rst (core_rst),
    .qual_hit (qual_hit),
    .rel_hit  (rel_hit)
  );

  rstctl_pof u_pof (
    .clk     (clk),
    .pwr_up  (pwr_up),
    .wr_en   (reg_wr_en),
    .wr_bit  (reg_wr_bit),
    .flag    (pof_rd),
    .clr_evt (pof_clr_evt)
  );

  assign port_pullup = core_rst;

  // R1
  qual_sets_rst_chk: assert property (@(posedge clk) disable iff (pwr_up)
    qual_hit |=> core_rst);

  // R3
  rel_clears_rst_chk: assert property (@(posedge clk) disable iff (pwr_up)
    rel_hit |=> !core_rst);

  // R7
  pin_keeps_flag_chk: assert property (@(posedge clk) disable iff (pwr_up)
    (qual_hit || rel_hit) && !pof_clr_evt |=> $stable(pof_rd));
endmodule

// File: tb/rstctl_top_tb.sv
module rstctl_top_tb;
  logic clk = 1'b0;
  logic mc_tick = 1'b0;
  logic rst_pin = 1'b0;
  logic pwr_up = 1'b0;
  logic reg_wr_en = 1'b0;
  logic reg_wr_bit = 1'b0;
  logic core_rst;
  logic pof_rd;
  logic port_pullup;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int phase = 0;
  bit done = 0;
  logic last_tick = 1'b0;
  logic last_pw = 1'b0;
  logic prev_rst = 1'b0;

  rstctl_top u_dut (
    .clk(clk), .mc_tick(mc_tick), .rst_pin(rst_pin), .pwr_up(pwr_up),
    .reg_wr_en(reg_wr_en), .reg_wr_bit(reg_wr_bit),
    .core_rst(core_rst), .pof_rd(pof_rd), .port_pullup(port_pullup)
  );

  always #10 clk = ~clk;

  // Strobe every 12 clocks, driven away from the active edge.
  always @(negedge clk) begin
    mc_tick <= (phase == 11);
    phase   <= (phase == 11) ? 0 : phase + 1;
  end

  always @(posedge clk) begin
    last_tick <= mc_tick;
    last_pw   <= pwr_up;
    cyc       <= cyc + 1;
    if (cyc > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // R1 R3: every change of core_rst happens on a strobe edge or after power-up
  always @(negedge clk) begin
    if (core_rst !== prev_rst) begin
      total++;
      if (!last_tick && !last_pw) begin
        bad++;
        $display("FAIL R1/R3 edge alignment act=tick0 exp=tick1");
      end
    end
    prev_rst = core_rst;
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (mc_tick !== 1'b1);
    @(negedge clk);
  endtask

  task automatic t_power_up(logic clr_too);
    pwr_up = 1'b1;
    reg_wr_en = clr_too; reg_wr_bit = 1'b0;
    step(1);
    pwr_up = 1'b0; reg_wr_en = 1'b0;
    chk("R5 core_rst after power-up", core_rst, 1'b1);
    chk(clr_too ? "R8 flag wins over clear" : "R5 flag set", pof_rd, 1'b1);
    chk("R9 pullup during reset", port_pullup, 1'b1);
    step(30);
    chk("R3 release after power-up", core_rst, 1'b0);
    chk("R9 pullup released", port_pullup, 1'b0);
  endtask

  task automatic t_qualify(logic exp_flag);
    wait_tick();
    rst_pin = 1'b1;
    step(23);
    chk("R1 not yet qualified", core_rst, 1'b0);
    step(1);
    chk("R1 qualified on second strobe", core_rst, 1'b1);
    chk("R9 pullup with pin reset", port_pullup, 1'b1);
    chk("R7 flag kept on pin reset", pof_rd, exp_flag);
  endtask

  task automatic t_release(logic exp_flag);
    wait_tick();
    rst_pin = 1'b0;
    step(11);
    chk("R3 held until strobe", core_rst, 1'b1);
    step(1);
    chk("R3 released on strobe", core_rst, 1'b0);
    chk("R7 flag kept on release", pof_rd, exp_flag);
  endtask

  task automatic t_glitch();
    logic seen = 1'b0;
    for (int p = 0; p < 2; p++) begin
      wait_tick();
      rst_pin = 1'b1;
      for (int i = 0; i < 14; i++) begin
        step(1);
        if (core_rst) seen = 1'b1;
      end
      rst_pin = 1'b0;
      for (int i = 0; i < 6; i++) begin
        step(1);
        if (core_rst) seen = 1'b1;
      end
    end
    chk("R2 short pulses ignored", seen, 1'b0);
  endtask

  task automatic t_rehigh();
    logic dropped = 1'b0;
    wait_tick();
    rst_pin = 1'b0;
    step(5);
    rst_pin = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (!core_rst) dropped = 1'b1;
    end
    chk("R4 pending release cancelled", dropped, 1'b0);
  endtask

  task automatic t_write(logic b, logic exp);
    reg_wr_en = 1'b1; reg_wr_bit = b;
    step(1);
    reg_wr_en = 1'b0;
    step(1);
    chk(b ? "R6 write 1 keeps flag" : "R6 write 0 clears flag", pof_rd, exp);
  endtask

  initial begin
    step(2);
    t_power_up(1'b0);
    t_qualify(1'b1);
    t_release(1'b1);
    t_glitch();
    t_write(1'b1, 1'b1);
    t_write(1'b0, 1'b0);
    t_qualify(1'b0);
    t_rehigh();
    t_release(1'b0);
    t_power_up(1'b1);
    t_write(1'b1, 1'b1);
    t_write(1'b0, 1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule